// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers sixteen interrupt sources for a small core with no coprocessor. Eight sources come from on-chip logic such as timer compare matches. Eight come from external pins. Each source sets a bit in a pending register. Software enables sources through a mask register. A single global enable bit in a status register gates the request to the core.

When a pending source is enabled and the global enable is set, the controller raises `irq_o`. The core's control unit answers with `irq_ack_i` and presents the return address on `ret_pc_i`. The controller then stores that address in its return-address register, clears the global enable and keeps the handler address on `vector_o`, where the core's fetch logic picks it up.

The handler clears the causes it has served by writing ones to the pending register. It then sets the global enable again and jumps back through the stored return address. All five registers sit behind a simple word-addressed read/write port on the data bus.

Top module: `irq_hub`

## Requirements
- R1: After reset the pending, mask, status and return-address registers read zero, the vector register reads parameter `VEC_RST` (default 0x0000_0100), and `irq_o` is low.
- R2: An internal source `int_src_i[i]` that is high at a rising clock edge sets pending bit i (bits 7:0). The bit stays set after the source falls until software clears it.
- R3: An external pin `ext_pin_i[j]` passes through two synchronizer flops and an edge flop. A rising edge sets pending bit 8+j on the third rising clock edge after the pin changes. A pin held high does not set the bit again after it is cleared.
- R4: A write to address 1 (pending) clears every bit written as 1 and leaves bits written as 0 unchanged.
- R5: `irq_o` is high exactly when (pending AND mask) is nonzero and status bit 0 is set. It follows register updates in the same cycle.
- R6: On a clock edge with `irq_ack_i` high, the return-address register captures `ret_pc_i` and status bit 0 is cleared.
- R7: Address 0 holds the handler vector. It is writable and readable, and `vector_o` always shows it.
- R8: While status bit 0 is clear, `irq_o` stays low whatever is pending, until software writes status bit 0 to 1.
- R9: When a source sets a pending bit in the same cycle as software clears it, the bit ends up set.
- R10: When `irq_ack_i` coincides with a software write of status, the acknowledge wins and status bit 0 ends up clear.
- R11: The map is: 0 vector, 1 pending, 2 mask (16 bits, upper bits read 0), 3 status (bit 0 only), 4 return address (read-only). Addresses 5 to 7 read zero. Reads return data only while `sel_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_src_i | input | 8 | Internal interrupt sources, level sampled each cycle |
| ext_pin_i | input | 8 | External interrupt pins, asynchronous, rising-edge sensitive |
| sel_i | input | 1 | Register port select |
| wr_i | input | 1 | Write strobe (with sel_i) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request to the core |
| irq_ack_i | input | 1 | Acknowledge from the core |
| ret_pc_i | input | 32 | Return address captured on acknowledge |
| vector_o | output | 32 | Handler address |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a source setting a pending bit while software clears it. The other is an acknowledge landing in the cycle where software rewrites status. The bench reaches both by driving the source or acknowledge and the bus write in the same low clock phase, so that one rising edge commits both. It then reads the result back through the register port. It also holds an external pin high across a software clear, to show that only a fresh edge sets the bit again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_VECTOR = 3'd0,
    A_CAUSE  = 3'd1,
    A_MASK   = 3'd2,
    A_STATUS = 3'd3,
    A_EPC    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-1:0], pin_i[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end

    assign edge_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end

  // R3: an edge indication lasts exactly one cycle
  p_edge_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_o) |=> ((edge_o & $past(edge_o)) == '0));
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q;
  logic [N-1:0] cause_d;
  logic         cause_en;

  always_comb begin
    cause_en = (|set_i) | (|clr_i);
    cause_d  = (cause_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  // R2, R9: a set request always lands, even against a clear
  p_set_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  // R4: cleared bits without a concurrent set go to zero
  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((cause_q & $past(clr_i & ~set_i)) == '0));

  // R2: pending bits never fall without a clear
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~cause_q & $past(cause_q & ~clr_i)) == '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned    DW      = 32,
  parameter int unsigned    NSRC    = 16,
  parameter logic [DW-1:0]  VEC_RST = 32'h0000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NSRC-1:0]   cause_i,
  output logic [NSRC-1:0]   clr_o,
  input  logic              ack_i,
  input  logic [DW-1:0]     ret_pc_i,
  output logic [NSRC-1:0]   mask_o,
  output logic              gie_o,
  output logic [DW-1:0]     vector_o
);
  logic            wr_en;
  logic [DW-1:0]   vec_q, vec_d;
  logic            vec_en;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            mask_en;
  logic            gie_q, gie_d;
  logic            gie_en;
  logic [DW-1:0]   epc_q, epc_d;
  logic            epc_en;
  logic            unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    wr_en   = sel_i & wr_i;
    vec_en  = wr_en && (addr_i == A_VECTOR);
    vec_d   = wdata_i;
    mask_en = wr_en && (addr_i == A_MASK);
    mask_d  = wdata_i[NSRC-1:0];
    epc_en  = ack_i;
    epc_d   = ret_pc_i;
    gie_en  = ack_i | (wr_en && (addr_i == A_STATUS));
    gie_d   = ack_i ? 1'b0 : wdata_i[0];
    clr_o   = (wr_en && (addr_i == A_CAUSE)) ? wdata_i[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= VEC_RST;
      mask_q <= '0;
      gie_q  <= 1'b0;
      epc_q  <= '0;
    end else begin
      if (vec_en)  vec_q  <= vec_d;
      if (mask_en) mask_q <= mask_d;
      if (gie_en)  gie_q  <= gie_d;
      if (epc_en)  epc_q  <= epc_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        A_VECTOR: rdata_o = vec_q;
        A_CAUSE:  rdata_o = DW'(cause_i);
        A_MASK:   rdata_o = DW'(mask_q);
        A_STATUS: rdata_o = DW'(gie_q);
        A_EPC:    rdata_o = epc_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign gie_o    = gie_q;
  assign vector_o = vec_q;

  // R6: the return address is taken on acknowledge
  p_epc_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (epc_q == $past(ret_pc_i)));

  // R10: acknowledge leaves global enable clear, whatever software wrote
  p_ack_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !gie_q);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqc_pkg::*;
#(
  parameter int unsigned   N_INT       = 8,
  parameter int unsigned   N_EXT       = 8,
  parameter int unsigned   DW          = 32,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [31:0]   VEC_RST     = 32'h0000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INT-1:0]  int_src_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  input  logic              irq_ack_i,
  input  logic [DW-1:0]     ret_pc_i,
  output logic [DW-1:0]     vector_o
);
  localparam int unsigned NSRC = N_INT + N_EXT;

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [N_EXT-1:0] ext_edge;
  logic [NSRC-1:0]  set_vec;
  logic [NSRC-1:0]  clr_vec;
  logic [NSRC-1:0]  cause;
  logic [NSRC-1:0]  mask;
  logic             gie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irqc_edge_sync #(.N(N_EXT), .STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pin_i  (ext_pin_i),
    .edge_o (ext_edge)
  );

  assign set_vec = {ext_edge, int_src_i};

  irqc_pending #(.N(NSRC)) i_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .cause_o (cause)
  );

  irqc_regs #(.DW(DW), .NSRC(NSRC), .VEC_RST(DW'(VEC_RST))) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cause_i  (cause),
    .clr_o    (clr_vec),
    .ack_i    (irq_ack_i),
    .ret_pc_i (ret_pc_i),
    .mask_o   (mask),
    .gie_o    (gie),
    .vector_o (vector_o)
  );

  assign irq_o = (|(cause & mask)) & gie;

  // R8: once acknowledged, no request until software re-enables
  p_quiet_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (irq_ack_i && !(sel_i && wr_i && addr_i == A_STATUS)) |=> !irq_o);
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/100ps
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  int_src;
  logic [7:0]  ext_pin;
  logic        sel, wr;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, ack;
  logic [31:0] ret_pc, vector;

  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  always #2 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .int_src_i(int_src), .ext_pin_i(ext_pin),
    .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .irq_ack_i(ack), .ret_pc_i(ret_pc), .vector_o(vector)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rdata;
          1:       act = {31'b0, irq};
          default: act = vector;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input int kind, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    #0.2;
    q.push_back(it);
    -> mon_ev;
    #0.2;
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    push(tag, 0, e);
    sel = 1'b0;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    push(tag, 1, {31'b0, e});
  endtask

  task automatic exp_vec(input logic [31:0] e, input string tag);
    push(tag, 2, e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; int_src = '0; ext_pin = '0; sel = 0; wr = 0;
    addr = '0; wdata = '0; ack = 0; ret_pc = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset values, R11 unmapped read
    exp_reg(3'd1, 32'h0, "R1 pending");
    exp_reg(3'd2, 32'h0, "R1 mask");
    exp_reg(3'd3, 32'h0, "R1 status");
    exp_reg(3'd4, 32'h0, "R1 epc");
    exp_reg(3'd0, 32'h0000_0100, "R1 vector");
    exp_irq(1'b0, "R1 irq");
    exp_reg(3'd6, 32'h0, "R11 unmapped");

    // R2 internal source latch; R5 mask zero keeps irq low
    tick(1);
    int_src[3] = 1'b1; tick(1); int_src[3] = 1'b0;
    exp_reg(3'd1, 32'h0000_0008, "R2 internal latch");
    tick(2);
    exp_reg(3'd1, 32'h0000_0008, "R2 held");
    exp_irq(1'b0, "R5 masked");

    // R11 mask width; R8 gie clear blocks irq; R5 irq rises
    tick(1);
    bus_wr(3'd2, 32'hABCD_0008);
    exp_reg(3'd2, 32'h0000_0008, "R11 mask width");
    exp_irq(1'b0, "R8 gie clear");
    tick(1);
    bus_wr(3'd3, 32'h0000_0003);
    exp_reg(3'd3, 32'h0000_0001, "R11 status bit0");
    exp_irq(1'b1, "R5 irq raised");

    // R6 acknowledge
    tick(1);
    ret_pc = 32'h0000_4A3C; ack = 1'b1; tick(1); ack = 1'b0;
    exp_reg(3'd4, 32'h0000_4A3C, "R6 epc");
    exp_reg(3'd3, 32'h0, "R6 status cleared");
    exp_irq(1'b0, "R8 no irq after ack");
    tick(1);
    bus_wr(3'd4, 32'hFFFF_FFFF);
    exp_reg(3'd4, 32'h0000_4A3C, "R11 epc read-only");

    // R7 vector
    tick(1);
    bus_wr(3'd0, 32'h0000_2200);
    exp_vec(32'h0000_2200, "R7 vector_o");
    exp_reg(3'd0, 32'h0000_2200, "R7 vector read");

    // R4 write-one-to-clear
    tick(1);
    int_src[0] = 1'b1; tick(1); int_src[0] = 1'b0;
    exp_reg(3'd1, 32'h0000_0009, "R2 second source");
    tick(1);
    bus_wr(3'd1, 32'h0000_0008);
    exp_reg(3'd1, 32'h0000_0001, "R4 clear one bit");
    tick(1);
    bus_wr(3'd1, 32'h0000_0000);
    exp_reg(3'd1, 32'h0000_0001, "R4 zero write no effect");

    // R3 external edge timing
    tick(1);
    ext_pin[2] = 1'b1;
    tick(2);
    exp_reg(3'd1, 32'h0000_0001, "R3 not before third edge");
    tick(1);
    exp_reg(3'd1, 32'h0000_0401, "R3 set on third edge");
    tick(1);
    bus_wr(3'd1, 32'h0000_0400);
    tick(4);
    exp_reg(3'd1, 32'h0000_0001, "R3 level does not re-set");
    ext_pin[2] = 1'b0;
    tick(4);
    ext_pin[2] = 1'b1;
    tick(3);
    exp_reg(3'd1, 32'h0000_0401, "R3 new edge");

    // R9 set beats clear
    tick(1);
    int_src[5] = 1'b1;
    sel = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 32'h0000_0020;
    tick(1);
    int_src[5] = 1'b0; sel = 1'b0; wr = 1'b0;
    exp_reg(3'd1, 32'h0000_0421, "R9 set wins");

    // R5 pattern with gie set but no enabled cause
    tick(1);
    bus_wr(3'd3, 32'h1);
    exp_irq(1'b0, "R5 no enabled cause");
    tick(1);
    bus_wr(3'd2, 32'h0000_0400);
    exp_irq(1'b1, "R5 external enabled");

    // R10 ack beats status write
    tick(1);
    ret_pc = 32'h0000_7770; ack = 1'b1;
    sel = 1'b1; wr = 1'b1; addr = 3'd3; wdata = 32'h1;
    tick(1);
    ack = 1'b0; sel = 1'b0; wr = 1'b0;
    exp_reg(3'd3, 32'h0, "R10 ack wins");
    exp_irq(1'b0, "R10 irq low");
    exp_reg(3'd4, 32'h0000_7770, "R6 second epc");

    // R8 re-enable
    tick(1);
    bus_wr(3'd3, 32'h1);
    exp_irq(1'b1, "R8 re-enabled");
    exp_reg(3'd5, 32'h0, "R11 addr5 zero");

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule